// File: doc/BRIEF.md
# Multi-Level Endpoint Request Arbiter

This block guards one shared memory endpoint. Several masters may ask for it in the same cycle. It grants at most one of them, and the grant appears combinationally in the cycle of the request. The choice is made in three layers. First, only the requests at the highest effective priority survive. Second, among those survivors, the master holding the largest signed fairness credit wins. Third, when credits are equal, the lowest master index wins.

Credits are zero-sum. After a contest among n survivors, the winner pays n-1 and every other survivor gains 1. Masters that did not compete keep their credit. A per-master loss counter lifts a request that has waited too long to the top priority level. The wait limit for each master is an input. A maintenance scrub request overrides the functional decision entirely.

Top module: `ep_arbiter`

## Requirements
- R1: `gnt` is one-hot or all zero. A bit is set only for a master whose `req_vld` bit is set.
- R2: Master i's priority is `req_pri[3i+2:3i]`, where 7 is the highest. Only valid requests at the highest effective priority present can be granted.
- R3: Among the surviving requests, the one with the largest credit wins. When credits are equal, the lowest index wins.
- R4: After a contest among n ≥ 2 survivors (no scrub), the winner's credit falls by n-1 and each other survivor's credit rises by 1. All other credits are unchanged.
- R5: The sum of all credits is zero at every cycle.
- R6: When exactly one request survives the first layer, it is granted and no credit changes.
- R7: Each master counts the cycles in which its valid request was not granted, and a grant clears this count. When the count is at least `starve_lim[8i+7:8i]`, the request's effective priority is 7. A limit of 0 therefore escalates the request always.
- R8: While `scrub_req` is high, `scrub_gnt` is high, `gnt` is zero and no credit changes. Each valid request counts that cycle as a loss.
- R9: A master that requests without pause is granted within its limit plus 4·N non-scrub waiting cycles.
- R10: Reset clears all credits and loss counts. The first full contest at equal priority is therefore won by master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | N | Request valid per master |
| req_pri | input | N*3 | Encoded priority per master |
| starve_lim | input | N*SW | Wait limit per master |
| scrub_req | input | 1 | Scrub request |
| gnt | output | N | One-hot functional grant |
| scrub_gnt | output | 1 | Scrub granted this cycle |

## Verification
Starvation escalation and the credit contest often land in the same cycle. A master whose count just reached its limit then meets other requests that are already at level 7. The random sweep uses small wait limits and clusters priorities at 7 to force this overlap. A bench model predicts every grant, and a wait-bound check runs on each grant. The scrub override is also mixed into those cycles. The model shows it freezes the credits while still adding a loss to every waiting request.

// File: rtl/ep_arbiter.sv
module ep_arbiter #(
  parameter int N  = 4,
  parameter int PW = 3,
  parameter int SW = 8,
  parameter int CW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_vld,
  input  logic [N*PW-1:0] req_pri,
  input  logic [N*SW-1:0] starve_lim,
  input  logic            scrub_req,
  output logic [N-1:0]    gnt,
  output logic            scrub_gnt
);
  localparam int CMAX = 2**(CW-1) - 1;
  localparam int CMIN = -(2**(CW-1));

  logic        [SW-1:0] wait_q [N];
  logic signed [CW-1:0] cred_q [N];
  logic        [PW-1:0] eff    [N];
  logic        [PW-1:0] top;
  logic        [N-1:0]  surv, fwin;
  logic        [N*CW-1:0] cred_flat;
  int                   nsurv, win;
  logic                 upd;

  function automatic logic signed [CW-1:0] sat(input int v);
    if (v > CMAX) return CMAX[CW-1:0];
    if (v < CMIN) return CMIN[CW-1:0];
    return v[CW-1:0];
  endfunction

  always_comb begin
    top = '0;
    for (int i = 0; i < N; i++) begin
      eff[i] = (wait_q[i] >= starve_lim[i*SW +: SW]) ? '1 : req_pri[i*PW +: PW];
      if (req_vld[i] && eff[i] > top) top = eff[i];
    end
    nsurv = 0;
    win   = 0;
    for (int i = 0; i < N; i++) begin
      surv[i] = req_vld[i] && (eff[i] == top);
      if (surv[i]) begin
        if (nsurv == 0 || cred_q[i] > cred_q[win]) win = i;
        nsurv++;
      end
    end
    fwin = '0;
    if (nsurv > 0) fwin[win] = 1'b1;
  end

  assign gnt       = scrub_req ? '0 : fwin;
  assign scrub_gnt = scrub_req;
  assign upd       = !scrub_req && nsurv > 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        wait_q[i] <= '0;
        cred_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (gnt[i]) wait_q[i] <= '0;
        else if (req_vld[i] && wait_q[i] != '1) wait_q[i] <= wait_q[i] + 1'b1;
        if (upd && surv[i])
          cred_q[i] <= sat(int'(cred_q[i]) + (fwin[i] ? 1 - nsurv : 1));
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign cred_flat[g*CW +: CW] = cred_q[g];
  end
endmodule

// File: rtl/ep_arbiter_chk.sv
module ep_arbiter_chk #(
  parameter int N  = 4,
  parameter int CW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_vld,
  input logic            scrub_req,
  input logic [N-1:0]    gnt,
  input logic            scrub_gnt,
  input logic [N*CW-1:0] cred_flat
);
  int csum;
  always_comb begin
    csum = 0;
    for (int i = 0; i < N; i++) csum += int'($signed(cred_flat[i*CW +: CW]));
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r1_grant_valid: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req_vld) == '0);
  a_r5_zero_sum: assert property (@(posedge clk) disable iff (!rst_n) csum == 0);
  a_r6_lone_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!scrub_req && $countones(req_vld) == 1) |-> gnt == req_vld);
  a_r6_credit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req_vld) <= 1) |=> $stable(cred_flat));
  a_r8_scrub_wins: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> (gnt == '0 && scrub_gnt));
  a_r8_credit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |=> $stable(cred_flat));
endmodule

bind ep_arbiter ep_arbiter_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .scrub_req(scrub_req),
  .gnt(gnt), .scrub_gnt(scrub_gnt), .cred_flat(cred_flat)
);

// File: tb/ep_arbiter_tb.sv
`timescale 1ns/1ps
module ep_arbiter_tb;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0]   req_vld = '0;
  logic [N*3-1:0] req_pri = '0;
  logic [N*8-1:0] starve_lim = '0;
  logic           scrub_req = 0;
  logic [N-1:0]   gnt;
  logic           scrub_gnt;

  ep_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_pri(req_pri),
    .starve_lim(starve_lim), .scrub_req(scrub_req), .gnt(gnt), .scrub_gnt(scrub_gnt));

  always #10 clk = ~clk;

  int cred[N], loss[N], waitc[N];
  int nchk = 0, nfail = 0;
  logic [31:0] rs = 32'h1234_5679;

  function automatic logic [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [N-1:0] a, input logic [N-1:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, a, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_vld = '0; scrub_req = 0;
    for (int i = 0; i < N; i++) begin cred[i] = 0; loss[i] = 0; waitc[i] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cyc(input logic [N-1:0] v, input logic [N*3-1:0] p, input logic s, input string tag);
    int eff[N]; int top, ns, w; logic [N-1:0] sv, eg;
    req_vld = v; req_pri = p; scrub_req = s;
    #5;
    top = 0;
    for (int i = 0; i < N; i++) begin
      eff[i] = (loss[i] >= int'(starve_lim[i*8 +: 8])) ? 7 : int'(p[i*3 +: 3]);
      if (v[i] && eff[i] > top) top = eff[i];
    end
    ns = 0; w = 0; sv = '0;
    for (int i = 0; i < N; i++)
      if (v[i] && eff[i] == top) begin
        sv[i] = 1;
        if (ns == 0 || cred[i] > cred[w]) w = i;
        ns++;
      end
    eg = '0;
    if (ns > 0 && !s) eg[w] = 1;
    check(gnt === eg && scrub_gnt === s, tag, gnt, eg);
    for (int i = 0; i < N; i++) begin
      if (eg[i] && !s) begin
        check(waitc[i] <= int'(starve_lim[i*8 +: 8]) + 4*N, "R9 wait bound",
              4'(waitc[i]), 4'(int'(starve_lim[i*8 +: 8]) + 4*N));
      end
      if (eg[i] || !v[i]) waitc[i] = 0; else if (!s) waitc[i]++;
      if (eg[i]) loss[i] = 0; else if (v[i] && loss[i] < 255) loss[i]++;
      if (!s && ns > 1 && sv[i]) begin
        cred[i] += (i == w) ? 1 - ns : 1;
        if (cred[i] > 31) cred[i] = 31;
        if (cred[i] < -32) cred[i] = -32;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    starve_lim = {4{8'd200}};
    do_reset();
    check(gnt === '0 && scrub_gnt === 0, "R10 idle after reset", gnt, '0);
    // fairness sequence: winners 0,1,2,3
    cyc(4'b1111, {4{3'd2}}, 0, "R10 R3 first contest");
    cyc(4'b1110, {4{3'd2}}, 0, "R4 contest B");
    cyc(4'b1101, {4{3'd2}}, 0, "R4 contest C");
    cyc(4'b1011, {4{3'd2}}, 0, "R4 R5 contest D");
    cyc(4'b0110, {3'd1, 3'd6, 3'd3, 3'd0}, 0, "R2 highest priority");
    cyc(4'b0100, {4{3'd0}}, 0, "R6 lone request");
    cyc(4'b1111, {4{3'd4}}, 1, "R8 scrub override");
    cyc(4'b1111, {4{3'd4}}, 0, "R8 credits frozen by scrub");
    // starvation escalation
    starve_lim = {8'd3, 8'd200, 8'd200, 8'd200};
    do_reset();
    for (int k = 0; k < 4; k++) cyc(4'b1111, {3'd0, 3'd5, 3'd5, 3'd5}, 0, "R7 escalation");
    cyc(4'b1111, {3'd0, 3'd5, 3'd5, 3'd5}, 0, "R7 reload after grant");
    starve_lim = {8'd200, 8'd0, 8'd200, 8'd200};
    cyc(4'b0101, {3'd0, 3'd0, 3'd0, 3'd6}, 0, "R7 zero limit");
    // sweeps
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < N; i++) starve_lim[i*8 +: 8] = 8'(rnd() % 7);
      do_reset();
      for (int k = 0; k < 3000; k++) begin
        logic [31:0] r; logic [N*3-1:0] p;
        r = rnd();
        for (int i = 0; i < N; i++)
          p[i*3 +: 3] = (r[8+3*i +: 2] == 2'b11) ? 3'd7 : (r[10+3*i] ? 3'd5 : 3'd2);
        cyc(ph == 2 ? 4'b1111 : r[3:0] | r[7:4], p, r[31:28] == 4'hF, "R2 R3 R4 R7 R8 sweep");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule